// File: doc/BRIEF.md
# Parallel-Port IDE Bridge Protocol Engine

This block sits on the adapter side of a bridge between a PC-style parallel port and a small IDE-style register file. The host drives an 8-bit data bus and an 8-bit control value. The block samples both on its own clock and reacts only to changes of the control value. A fixed four-step handshake on the control lines captures an address byte. That byte selects a register, picks the transfer mode, or deselects the adapter.

Once the adapter is selected, the host can write registers with a two-edge strobe. It can read a register as two nibbles on four status lines. It can also read a run of bytes in byte mode, where the block turns the data bus around while a direction bit in the control value is set. A 32-byte register array inside the block stands in for the drive's task file. Its access bus (index, write data, read and write strobes) is brought out as registered outputs.

Top module: `ppide_bridge`

## Requirements
- R1: While `rst` is high and in the cycle after it, `host_data_oe`, `host_status_o`, `reg_wr_o` and `reg_rd_o` are zero. After reset the adapter is deselected, so control value 0x06 gives status 0.
- R2: The address byte on `host_data_i` is captured only when the control value changes to 0x0C, then 0x0E, then 0x0C, then 0x04. Repeated equal values count as one step. A broken sequence (for example 0x0C, 0x0E, 0x04) leaves the previous address in force.
- R3: The register index is the low five bits of the captured address. Base offsets 0x08 and 0x10 therefore reach distinct registers; for example 0x0A is index 10 and 0x12 is index 18.
- R4: In a selected, non-byte mode, a change of control from 0x05 to 0x07 writes the sampled data byte into the indexed register. It pulses `reg_wr_o` for exactly one cycle, with `reg_addr_o` set to the index and `reg_wdata_o` set to the byte.
- R5: In a selected, non-byte mode, control 0x06 puts bits 3:0 of the indexed register on `host_status_o`, and control 0x04 puts bits 7:4 there. With any other control value, `host_status_o` is 0. A host that forms ((first>>4)&0x0F)|(second&0xF0) from the two status bytes (these four lines being status bits 7:4) recovers the register value.
- R6: Repeated 0x07/0x05 strobes after a single address capture write each new data byte to the same register. There is one `reg_wr_o` pulse per strobe, and the last byte remains.
- R7: An address with bits 7:6 equal to 11 selects byte mode. The first change to 0xA6 or 0xA4 presents the indexed register on `host_data_o`. Each later change between 0xA6 and 0xA4 moves to the next index, wrapping modulo 32.
- R8: `host_data_oe` is high only in byte mode while bit 5 of the control value is set. Control 0xAC ends byte mode, so the bus is released at 0xAC and stays released through the following 0xA4 and 0x04.
- R9: Capturing address 0x20 deselects the adapter. While it is deselected, write strobes change no register and pulse no `reg_wr_o`, and the status lines stay 0.
- R10: `reg_rd_o` pulses once for each change to 0x06 in nibble mode and once for each byte fetched in byte mode. It is never high together with `reg_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data_i | input | 8 | Data byte from the host |
| host_ctrl_i | input | 8 | Host control value; bit 5 is the direction bit |
| host_data_o | output | 8 | Byte driven toward the host in byte mode |
| host_data_oe | output | 1 | Output enable for `host_data_o` |
| host_status_o | output | 4 | Status lines carrying one register nibble |
| reg_addr_o | output | 5 | Register index of the current access |
| reg_wdata_o | output | 8 | Data of the current write |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |

## Verification
The assertions assume that the host holds each control value for at least two clocks. This keeps a write strobe and the sampled control history in a fixed cycle relation. They also assume that `rst` is asserted from time zero. The stimulus holds every control step for six clocks and sets data bytes before the strobe edge. All random traffic (register writes, nibble reads, byte-mode runs of random length and start index) is built from these same stepped sequences, so no random choice can violate the timing assumption.

// File: rtl/ppide_pkg.sv
package ppide_pkg;
  localparam int CTRL_W = 8;
  localparam int DIR_BIT = 5;

  localparam logic [CTRL_W-1:0] CT_REST  = 8'h04;
  localparam logic [CTRL_W-1:0] CT_SEL_A = 8'h0C;
  localparam logic [CTRL_W-1:0] CT_SEL_B = 8'h0E;
  localparam logic [CTRL_W-1:0] CT_NIBLO = 8'h06;
  localparam logic [CTRL_W-1:0] CT_WR_LO = 8'h05;
  localparam logic [CTRL_W-1:0] CT_WR_HI = 8'h07;
  localparam logic [CTRL_W-1:0] CT_BYT_A = 8'hA4;
  localparam logic [CTRL_W-1:0] CT_BYT_B = 8'hA6;
  localparam logic [CTRL_W-1:0] CT_BYT_X = 8'hAC;

  localparam logic [7:0] ADDR_RELEASE = 8'h20;

  typedef enum logic [1:0] {
    HS_WAIT,
    HS_STEP1,
    HS_STEP2,
    HS_STEP3
  } hs_state_t;

  function automatic logic is_byte_phase(input logic [CTRL_W-1:0] c);
    return (c == CT_BYT_A) || (c == CT_BYT_B);
  endfunction
endpackage

// File: rtl/ppide_addr_seq.sv
module ppide_addr_seq
  import ppide_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_cur,
  input  logic [CTRL_W-1:0] ctrl_prev,
  input  logic [DATA_W-1:0] data_cur,
  output logic              cap_stb,
  output logic [DATA_W-1:0] cap_addr
);
  hs_state_t st_q;
  logic      moved;

  assign moved    = ctrl_cur != ctrl_prev;
  assign cap_stb  = moved && (st_q == HS_STEP3) && (ctrl_cur == CT_REST);
  assign cap_addr = data_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= HS_WAIT;
    end else if (moved) begin
      if (ctrl_cur == CT_SEL_A)
        st_q <= (st_q == HS_STEP2) ? HS_STEP3 : HS_STEP1;
      else if (ctrl_cur == CT_SEL_B && st_q == HS_STEP1)
        st_q <= HS_STEP2;
      else
        st_q <= HS_WAIT;
    end
  end
endmodule

// File: rtl/ppide_regfile.sv
module ppide_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ppide_bridge.sv
module ppide_bridge
  import ppide_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int NIB_W   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic [CTRL_W-1:0] host_ctrl_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe,
  output logic [NIB_W-1:0]  host_status_o,
  output logic [IDX_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_prev_q;
  logic [DATA_W-1:0] data_q;
  logic              cap_stb;
  logic [DATA_W-1:0] cap_addr;
  logic              sel_q, bytemode_q;
  logic [IDX_W-1:0]  idx_q, ptr_q, raddr;
  logic [DATA_W-1:0] rdata;
  logic              moved, wr_ev, nib_rd_ev, byte_rd_ev, adv_ev, end_ev;

  // input sampling: host lines are registered once, previous value kept for edges
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= CT_REST;
      ctrl_prev_q <= CT_REST;
      data_q      <= '0;
    end else begin
      ctrl_q      <= host_ctrl_i;
      ctrl_prev_q <= ctrl_q;
      data_q      <= host_data_i;
    end
  end

  ppide_addr_seq #(.DATA_W(DATA_W)) hs_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl_cur (ctrl_q),
    .ctrl_prev(ctrl_prev_q),
    .data_cur (data_q),
    .cap_stb  (cap_stb),
    .cap_addr (cap_addr)
  );

  assign moved      = ctrl_q != ctrl_prev_q;
  assign wr_ev      = sel_q && !bytemode_q && moved &&
                      ctrl_prev_q == CT_WR_LO && ctrl_q == CT_WR_HI;
  assign nib_rd_ev  = sel_q && !bytemode_q && moved && ctrl_q == CT_NIBLO;
  assign byte_rd_ev = sel_q && bytemode_q && moved && is_byte_phase(ctrl_q);
  assign adv_ev     = byte_rd_ev && is_byte_phase(ctrl_prev_q);
  assign end_ev     = bytemode_q && moved && ctrl_q == CT_BYT_X;

  // selection, mode and pointer state
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= 1'b0;
      bytemode_q <= 1'b0;
      idx_q      <= '0;
      ptr_q      <= '0;
    end else if (cap_stb) begin
      sel_q      <= cap_addr != DATA_W'(ADDR_RELEASE);
      bytemode_q <= (cap_addr != DATA_W'(ADDR_RELEASE)) &&
                    (cap_addr[DATA_W-1:DATA_W-2] == 2'b11);
      idx_q      <= cap_addr[IDX_W-1:0];
      ptr_q      <= cap_addr[IDX_W-1:0];
    end else begin
      if (end_ev) bytemode_q <= 1'b0;
      if (adv_ev) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign raddr = bytemode_q ? ptr_q : idx_q;

  ppide_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) rf_i (
    .clk  (clk),
    .we   (wr_ev),
    .waddr(idx_q),
    .wdata(data_q),
    .raddr(raddr),
    .rdata(rdata)
  );

  // registered outputs toward host and register bus
  always_ff @(posedge clk) begin
    if (rst) begin
      host_data_o   <= '0;
      host_data_oe  <= 1'b0;
      host_status_o <= '0;
      reg_addr_o    <= '0;
      reg_wdata_o   <= '0;
      reg_wr_o      <= 1'b0;
      reg_rd_o      <= 1'b0;
    end else begin
      host_data_o  <= rdata;
      host_data_oe <= bytemode_q && ctrl_q[DIR_BIT];
      if (sel_q && !bytemode_q && ctrl_q == CT_NIBLO)
        host_status_o <= rdata[NIB_W-1:0];
      else if (sel_q && !bytemode_q && ctrl_q == CT_REST)
        host_status_o <= rdata[DATA_W-1:NIB_W];
      else
        host_status_o <= '0;
      reg_addr_o  <= wr_ev ? idx_q : raddr;
      reg_wdata_o <= data_q;
      reg_wr_o    <= wr_ev;
      reg_rd_o    <= nib_rd_ev || byte_rd_ev;
    end
  end
endmodule

// File: rtl/ppide_checker.sv
module ppide_checker #(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] host_ctrl_i,
  input logic              host_data_oe,
  input logic [NIB_W-1:0]  host_status_o,
  input logic              reg_wr_o,
  input logic              reg_rd_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!host_data_oe && host_status_o == '0 && !reg_wr_o && !reg_rd_o));

  // R8
  oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
    host_data_oe |-> $past(host_ctrl_i[5], 2));

  // R4
  wr_edge_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> ($past(host_ctrl_i, 2) == 8'h07));

  // R4
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_o && reg_rd_o));

  // R5
  status_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (host_status_o != '0) |-> !host_data_oe);
endmodule

bind ppide_bridge ppide_checker #(.DATA_W(8), .CTRL_W(8), .NIB_W(4)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .host_ctrl_i  (host_ctrl_i),
  .host_data_oe (host_data_oe),
  .host_status_o(host_status_o),
  .reg_wr_o     (reg_wr_o),
  .reg_rd_o     (reg_rd_o)
);

// File: tb/ppide_bridge_tb_top.sv
module ppide_bridge_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] host_data_i = 8'h00;
  logic [7:0] host_ctrl_i = 8'h04;
  logic [7:0] host_data_o;
  logic       host_data_oe;
  logic [3:0] host_status_o;
  logic [4:0] reg_addr_o;
  logic [7:0] reg_wdata_o;
  logic       reg_wr_o;
  logic       reg_rd_o;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [4:0] last_wr_addr;
  logic [7:0] last_wr_data;
  logic [7:0] ref_mem [32];

  always #5 clk = ~clk;

  ppide_bridge dut_i (
    .clk(clk), .rst(rst), .host_data_i(host_data_i), .host_ctrl_i(host_ctrl_i),
    .host_data_o(host_data_o), .host_data_oe(host_data_oe),
    .host_status_o(host_status_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o)
  );

  always @(posedge clk) begin
    if (!rst && reg_wr_o) begin
      wr_cnt++;
      last_wr_addr = reg_addr_o;
      last_wr_data = reg_wdata_o;
    end
    if (!rst && reg_rd_o) rd_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rebuild(input logic [7:0] first, input logic [7:0] second);
    return ((first >> 4) & 8'h0F) | (second & 8'hF0);
  endfunction

  task automatic step(input logic [7:0] c);
    @(negedge clk);
    host_ctrl_i = c;
    repeat (6) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    host_data_i = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic select_addr(input logic [7:0] a);
    put(a);
    step(8'h04); step(8'h0C); step(8'h0E); step(8'h0E); step(8'h0C); step(8'h04);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
    select_addr(a);
    put(v);
    step(8'h05); step(8'h07); step(8'h05); step(8'h04);
    if (a != 8'h20) ref_mem[a[4:0]] = v;
  endtask

  task automatic rd_nib(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] lo, hi;
    select_addr(a);
    step(8'h06); lo = {host_status_o, 4'h0};
    step(8'h04); hi = {host_status_o, 4'h0};
    v = rebuild(lo, hi);
  endtask

  task automatic rd_bytes(input logic [4:0] idx, input int n, input string req);
    int rd0;
    select_addr(8'hC0 | {3'b000, idx});
    put(8'hFF);
    rd0 = rd_cnt;
    for (int k = 0; k < n; k++) begin
      logic [4:0] p;
      p = idx + 5'(k);
      step((k % 2 == 0) ? 8'hA6 : 8'hA4);
      chk(host_data_oe == 1'b1, "R8", host_data_oe, 1);
      chk(host_data_o == ref_mem[p], req, host_data_o, ref_mem[p]);
    end
    chk(rd_cnt - rd0 == n, "R10", rd_cnt - rd0, n);
    step(8'hAC); chk(host_data_oe == 1'b0, "R8", host_data_oe, 0);
    step(8'hA4); chk(host_data_oe == 1'b0, "R8", host_data_oe, 0);
    step(8'h04); chk(host_data_oe == 1'b0, "R8", host_data_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(host_data_oe == 0, "R1", host_data_oe, 0);
    chk(host_status_o == 0, "R1", host_status_o, 0);
    chk(reg_wr_o == 0 && reg_rd_o == 0, "R1", {reg_wr_o, reg_rd_o}, 0);
    rst = 1'b0;
    step(8'h06);
    chk(host_status_o == 0, "R1", host_status_o, 0);
    step(8'h04);

    // fill every register with a known value
    for (int i = 0; i < 32; i++) wr_reg(8'(i), 8'($urandom));

    // R4 directed write and strobe contents
    w0 = wr_cnt;
    wr_reg(8'h0B, 8'h5A);
    chk(wr_cnt - w0 == 1, "R4", wr_cnt - w0, 1);
    chk(last_wr_addr == 5'd11, "R4", last_wr_addr, 11);
    chk(last_wr_data == 8'h5A, "R4", last_wr_data, 8'h5A);
    rd_nib(8'h0B, v);
    chk(v == 8'h5A, "R5", v, 8'h5A);

    // R5 non-nibble control value gives zero status
    step(8'h05);
    chk(host_status_o == 0, "R5", host_status_o, 0);
    step(8'h04);

    // R3 two base offsets reach distinct registers
    wr_reg(8'h0A, 8'hC3);
    wr_reg(8'h12, 8'h3C);
    rd_nib(8'h0A, v); chk(v == 8'hC3, "R3", v, 8'hC3);
    rd_nib(8'h12, v); chk(v == 8'h3C, "R3", v, 8'h3C);

    // R2 broken handshake keeps the previous address
    select_addr(8'h0A);
    put(8'h12);
    step(8'h0C); step(8'h0E); step(8'h04);
    step(8'h06); v[3:0] = host_status_o;
    step(8'h04); v[7:4] = host_status_o;
    chk(v == 8'hC3, "R2", v, 8'hC3);

    // R6 streaming writes to one register
    w0 = wr_cnt;
    select_addr(8'h08);
    step(8'h05);
    for (int k = 0; k < 4; k++) begin
      put(8'h10 + 8'(k));
      step(8'h07); step(8'h05);
    end
    step(8'h04);
    ref_mem[8] = 8'h13;
    chk(wr_cnt - w0 == 4, "R6", wr_cnt - w0, 4);
    rd_nib(8'h08, v); chk(v == 8'h13, "R6", v, 8'h13);

    // R9 deselect blocks writes and status
    w0 = wr_cnt;
    select_addr(8'h20);
    put(8'hEE);
    step(8'h05); step(8'h07); step(8'h05); step(8'h04);
    chk(wr_cnt == w0, "R9", wr_cnt - w0, 0);
    step(8'h06); chk(host_status_o == 0, "R9", host_status_o, 0);
    step(8'h04); chk(host_status_o == 0, "R9", host_status_o, 0);
    rd_nib(8'h08, v); chk(v == 8'h13, "R9", v, 8'h13);

    // R7 byte mode including index wrap
    rd_bytes(5'd4, 5, "R7");
    rd_bytes(5'd30, 4, "R7");

    // R10 nibble read strobe
    w0 = rd_cnt;
    rd_nib(8'h05, v);
    chk(rd_cnt - w0 == 1, "R10", rd_cnt - w0, 1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [4:0] ri;
      ri = 5'($urandom);
      case ($urandom % 3)
        0: wr_reg({3'b000, ri}, 8'($urandom));
        1: begin
          rd_nib({3'b000, ri}, v);
          chk(v == ref_mem[ri], "R5", v, ref_mem[ri]);
        end
        default: rd_bytes(ri, 2 + int'($urandom % 5), "R7");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule